// File: doc/BRIEF.md
# Register-Controlled 64-bit Rotate and Clear-Left Unit

This block executes one integer instruction: it rotates a 64-bit source operand left by an amount taken from a second register, then clears the high-order bits above a boundary given in the instruction word. An external register file supplies both operand values. The block recognises the instruction from a 32-bit word, takes the destination index and the split mask field out of that word, builds the mask, and forms the result. It also computes an optional update of condition field 0.

Bits of the instruction word are numbered big-endian, so big-endian bit 0 is `instr[31]`. Every output is registered and appears on the clock edge after the `valid` strobe. When the word is not this instruction, both write enables stay low and every data output reads zero.

Top module: `rotclr_unit`

## Requirements
- R1: `match` and `ra_we` are high one cycle after a cycle in which `valid` is high, `instr[31:26]` equals 30 and `instr[4:1]` equals 4'b1000. No other instruction bit takes part in recognition.
- R2: `ra_idx` carries `instr[20:16]` from the matched word.
- R3: The rotate amount is `rb_val[5:0]`. Bits `rb_val[63:6]` have no effect on any output.
- R4: The mask-begin value MB is 6 bits wide. Its top bit is `instr[5]` and its lower five bits are `instr[10:6]`.
- R5: `ra_data` is the source rotated left by the amount, ANDed with a mask in which little-endian bit i is 1 exactly when i <= 63-MB. MB=0 gives all ones and MB=63 keeps only bit 0.
- R6: Every amount from 0 to 63 is handled, and an amount of 0 passes `rs_val` to the mask unchanged.
- R7: `cr0_we` is high exactly when `match` is high and the matched word had `instr[0]` = 1. When it is high, `cr0[3]`=LT, `cr0[2]`=GT and `cr0[1]`=EQ come from a signed 64-bit compare of `ra_data` against zero. When it is low, `cr0` reads 0.
- R8: When `cr0_we` is high, `cr0[0]` equals `so_in` from the issue cycle.
- R9: When `match` is low, `ra_we`, `cr0_we`, `ra_idx`, `ra_data` and `cr0` are all zero.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word; `instr[31]` is big-endian bit 0 |
| rs_val | input | 64 | Source operand value |
| rb_val | input | 64 | Shift operand value; only bits 5:0 are used |
| so_in | input | 1 | Sticky summary-overflow bit |
| match | output | 1 | Registered: the issued word was this instruction |
| ra_idx | output | 5 | Destination register index |
| ra_we | output | 1 | Destination write enable |
| ra_data | output | 64 | Rotated and masked result |
| cr0_we | output | 1 | Condition field 0 write enable (record form) |
| cr0 | output | 4 | {LT, GT, EQ, SO} |

## Verification
The assertions assume that `instr`, `rs_val`, `rb_val` and `so_in` are stable across each rising edge at which `valid` is sampled, because they compare outputs against the `$past` values of those inputs. The stimulus changes every input only on the falling edge, and it holds `valid` high through each issue. It sweeps all 64 MB values against all 64 rotate amounts with random source words and random upper shift bits. Directed words cover the sign-bit-set, zero and positive results, and near-miss opcodes.

// File: rtl/rotclr_pkg.sv
package rotclr_pkg;

  localparam int unsigned XLEN     = 64;
  localparam int unsigned AMT_W    = $clog2(XLEN);
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned IWORD_W  = 32;
  localparam int unsigned CR_W     = 4;

  localparam logic [5:0] PRIMARY_OP = 6'd30;
  localparam logic [3:0] EXT_OP     = 4'b1000;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

endpackage

// File: rtl/rotclr_decode.sv
module rotclr_decode
  import rotclr_pkg::*;
(
  input  logic [IWORD_W-1:0] instr,
  output logic               hit,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [AMT_W-1:0]   mb,
  output logic               rec
);

  logic [5:0] op_field;
  logic [3:0] xo_field;
  logic [4:0] mb_low;
  logic       mb_top;

  always_comb begin
    op_field = instr[31:26];
    xo_field = instr[4:1];
    mb_low   = instr[10:6];
    mb_top   = instr[5];
  end

  always_comb begin
    hit     = (op_field == PRIMARY_OP) && (xo_field == EXT_OP);
    dst_idx = instr[20:16];
    mb      = {mb_top, mb_low};
    rec     = instr[0];
  end

endmodule

// File: rtl/rotclr_rotl.sv
module rotclr_rotl #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    logic [W-1:0] turned;
    assign turned       = {stage[s][W-1-K:0], stage[s][W-1:W-K]};
    assign stage[s+1]   = amt[s] ? turned : stage[s];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/rotclr_mask.sv
module rotclr_mask #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] mb,
  output logic [W-1:0]  mask
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SW-1:0] LIMIT = SW'(W - 1 - i);
    assign mask[i] = (mb <= LIMIT);
  end

endmodule

// File: rtl/rotclr_cond.sv
module rotclr_cond
  import rotclr_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res,
  input  logic         so,
  output crf_t         crf
);

  logic neg;
  logic zero;

  always_comb begin
    neg     = res[W-1];
    zero    = ~|res;
    crf.lt  = neg;
    crf.eq  = zero;
    crf.gt  = ~neg & ~zero;
    crf.so  = so;
  end

endmodule

// File: rtl/rotclr_unit.sv
module rotclr_unit
  import rotclr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [IWORD_W-1:0]  instr,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rb_val,
  input  logic                so_in,
  output logic                match,
  output logic [IDX_W-1:0]    ra_idx,
  output logic                ra_we,
  output logic [XLEN-1:0]     ra_data,
  output logic                cr0_we,
  output logic [CR_W-1:0]     cr0
);

  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;
  logic [AMT_W-1:0]   dec_mb;
  logic               dec_rec;
  logic [AMT_W-1:0]   amt;
  logic [XLEN-1:0]    rotated;
  logic [XLEN-1:0]    mask;
  logic [XLEN-1:0]    result;
  crf_t               crf;

  logic               match_q,  match_d;
  logic [IDX_W-1:0]   idx_q,    idx_d;
  logic [XLEN-1:0]    data_q,   data_d;
  logic               crwe_q,   crwe_d;
  logic [CR_W-1:0]    cr_q,     cr_d;
  logic               ld_en;
  logic               take;

  rotclr_decode i_decode (
    .instr   (instr),
    .hit     (dec_hit),
    .dst_idx (dec_idx),
    .mb      (dec_mb),
    .rec     (dec_rec)
  );

  assign amt = rb_val[AMT_W-1:0];

  rotclr_rotl #(.W(XLEN), .SW(AMT_W)) i_rotl (
    .din  (rs_val),
    .amt  (amt),
    .dout (rotated)
  );

  rotclr_mask #(.W(XLEN), .SW(AMT_W)) i_mask (
    .mb   (dec_mb),
    .mask (mask)
  );

  assign result = rotated & mask;

  rotclr_cond #(.W(XLEN)) i_cond (
    .res (result),
    .so  (so_in),
    .crf (crf)
  );

  always_comb begin
    take    = valid & dec_hit;
    match_d = take;
    idx_d   = take ? dec_idx : '0;
    data_d  = take ? result  : '0;
    crwe_d  = take & dec_rec;
    cr_d    = crwe_d ? crf : '0;
    ld_en   = valid | match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      crwe_q  <= 1'b0;
      cr_q    <= '0;
    end else if (ld_en) begin
      match_q <= match_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      crwe_q  <= crwe_d;
      cr_q    <= cr_d;
    end
  end

  assign match   = match_q;
  assign ra_we   = match_q;
  assign ra_idx  = idx_q;
  assign ra_data = data_q;
  assign cr0_we  = crwe_q;
  assign cr0     = cr_q;

endmodule

// File: rtl/rotclr_chk.sv
module rotclr_chk
  import rotclr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                valid,
  input logic [IWORD_W-1:0]  instr,
  input logic                so_in,
  input logic                match,
  input logic [IDX_W-1:0]    ra_idx,
  input logic                ra_we,
  input logic [XLEN-1:0]     ra_data,
  input logic                cr0_we,
  input logic [CR_W-1:0]     cr0
);

  logic [AMT_W-1:0] mb_now;
  logic [XLEN-1:0]  ones;

  assign mb_now = {instr[5], instr[10:6]};
  assign ones   = '1;

  AST_MATCH_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(valid) && ($past(instr[31:26]) == PRIMARY_OP) && ($past(instr[4:1]) == EXT_OP)); // R1
  AST_WE_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we == match); // R1
  AST_DEST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ra_idx == $past(instr[20:16])); // R2
  AST_MASK_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (ra_data & ~(ones >> $past(mb_now))) == '0); // R5
  AST_RECORD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we == (match && $past(instr[0]))); // R7
  AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we |-> $countones(cr0[3:1]) == 1); // R7
  AST_CR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we |-> (cr0[3] == ra_data[XLEN-1]) && (cr0[1] == (ra_data == '0))); // R7
  AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we |-> cr0[0] == $past(so_in)); // R8
  AST_QUIET_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> !cr0_we && (ra_idx == '0) && (ra_data == '0) && (cr0 == '0)); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!match && !ra_we && !cr0_we && ra_data == '0 && cr0 == '0 && ra_idx == '0); // R10
    end
  end

endmodule

bind rotclr_unit rotclr_chk i_rotclr_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid   (valid),
  .instr   (instr),
  .so_in   (so_in),
  .match   (match),
  .ra_idx  (ra_idx),
  .ra_we   (ra_we),
  .ra_data (ra_data),
  .cr0_we  (cr0_we),
  .cr0     (cr0)
);

// File: tb/test_rotclr_unit.sv
`timescale 1ns/1ps
module test_rotclr_unit;

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [31:0] instr;
  logic [63:0] rs_val;
  logic [63:0] rb_val;
  logic        so_in;
  logic        match;
  logic [4:0]  ra_idx;
  logic        ra_we;
  logic [63:0] ra_data;
  logic        cr0_we;
  logic [3:0]  cr0;

  int checks;
  int errors;

  rotclr_unit i_rotclr_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .instr   (instr),
    .rs_val  (rs_val),
    .rb_val  (rb_val),
    .so_in   (so_in),
    .match   (match),
    .ra_idx  (ra_idx),
    .ra_we   (ra_we),
    .ra_data (ra_data),
    .cr0_we  (cr0_we),
    .cr0     (cr0)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk_word(input logic [4:0] rs, input logic [4:0] ra,
                                          input logic [4:0] rb, input logic [5:0] mb,
                                          input logic rc);
    return {6'd30, rs, ra, rb, mb[4:0], mb[5], 4'b1000, rc};
  endfunction

  function automatic logic [63:0] ref_result(input logic [63:0] src, input int amt, input int mb);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = src[(i - amt + 64) % 64];
      if (i > 63 - mb) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w, input logic [63:0] s,
                       input logic [63:0] b, input logic so);
    @(negedge clk);
    valid  = v;
    instr  = w;
    rs_val = s;
    rb_val = b;
    so_in  = so;
    @(negedge clk);
  endtask

  task automatic check_hit(input string req, input logic [31:0] w, input logic [63:0] s,
                           input logic [63:0] b, input logic so);
    logic [63:0] exp;
    logic [3:0]  ecr;
    int          mbv;
    mbv = int'({w[5], w[10:6]});
    exp = ref_result(s, int'(b[5:0]), mbv);
    if (w[0]) begin
      ecr[3] = $signed(exp) < 0;
      ecr[2] = $signed(exp) > 0;
      ecr[1] = exp == 64'd0;
      ecr[0] = so;
    end else begin
      ecr = 4'd0;
    end
    issue(1'b1, w, s, b, so);
    check(req, "match", 64'(match), 64'd1);
    check(req, "ra_we", 64'(ra_we), 64'd1);
    check(req, "ra_idx", 64'(ra_idx), 64'(w[20:16]));
    check(req, "ra_data", ra_data, exp);
    check(req, "cr0_we", 64'(cr0_we), 64'(w[0]));
    check(req, "cr0", 64'(cr0), 64'(ecr));
  endtask

  task automatic check_quiet(input string req, input logic v, input logic [31:0] w);
    issue(v, w, rnd64(), rnd64(), 1'b1);
    check(req, "match", 64'(match), 64'd0);
    check(req, "ra_we", 64'(ra_we), 64'd0);
    check(req, "cr0_we", 64'(cr0_we), 64'd0);
    check(req, "ra_idx", 64'(ra_idx), 64'd0);
    check(req, "ra_data", ra_data, 64'd0);
    check(req, "cr0", 64'(cr0), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    valid  = 1'b1;
    instr  = mk_word(5'd1, 5'd2, 5'd3, 6'd0, 1'b1);
    rs_val = 64'hFFFF_0000_1234_5678;
    rb_val = 64'd4;
    so_in  = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero during reset despite a valid matching word
    check("R10", "match", 64'(match), 64'd0);
    check("R10", "ra_data", ra_data, 64'd0);
    check("R10", "cr0", 64'(cr0), 64'd0);
    check("R10", "cr0_we", 64'(cr0_we), 64'd0);
    valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R4 R3: every MB against every amount, random source and random upper shift bits
    for (int mb = 0; mb < 64; mb++) begin
      for (int amt = 0; amt < 64; amt++) begin
        logic [63:0] b;
        b = {rnd64() >> 6, 6'(amt)};
        check_hit("R5", mk_word(5'(mb), 5'(amt), 5'(mb + amt), 6'(mb), 1'(amt[0])),
                  rnd64(), b, 1'($urandom()));
      end
    end

    // R6: amount 0 with MB 0 passes the source unchanged
    check_hit("R6", mk_word(5'd4, 5'd9, 5'd6, 6'd0, 1'b0), 64'hDEAD_BEEF_0123_4567, 64'd0, 1'b0);
    check_hit("R6", mk_word(5'd4, 5'd9, 5'd6, 6'd0, 1'b0), 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0);

    // R5: boundary masks
    check_hit("R5", mk_word(5'd1, 5'd1, 5'd1, 6'd63, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd17, 1'b0);
    check_hit("R5", mk_word(5'd1, 5'd1, 5'd1, 6'd32, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);

    // R4: MB 32 (top bit only from instr[5]) vs MB 1 (lowest bit from instr[6])
    check_hit("R4", {6'd30, 15'd0, 5'd0, 1'b1, 4'b1000, 1'b0}, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    check_hit("R4", {6'd30, 15'd0, 5'd1, 1'b0, 4'b1000, 1'b0}, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);

    // R3: large upper bits in the shift operand are ignored
    check_hit("R3", mk_word(5'd2, 5'd3, 5'd4, 6'd0, 1'b1), 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FF41, 1'b0);

    // R7: negative, zero and positive records; R8 SO copied both ways
    check_hit("R7", mk_word(5'd0, 5'd7, 5'd0, 6'd0, 1'b1), 64'h0000_0000_0000_0001, 64'd63, 1'b0);
    check_hit("R7", mk_word(5'd0, 5'd7, 5'd0, 6'd1, 1'b1), 64'h0000_0000_0000_0001, 64'd63, 1'b1);
    check_hit("R7", mk_word(5'd0, 5'd7, 5'd0, 6'd0, 1'b1), 64'h0000_0000_8000_0000, 64'd0, 1'b0);
    check_hit("R8", mk_word(5'd0, 5'd7, 5'd0, 6'd0, 1'b1), 64'h0000_0000_0000_0000, 64'd5, 1'b1);
    check_hit("R8", mk_word(5'd0, 5'd7, 5'd0, 6'd0, 1'b1), 64'h7000_0000_0000_0000, 64'd0, 1'b1);
    check_hit("R7", mk_word(5'd0, 5'd7, 5'd0, 6'd0, 1'b0), 64'h8000_0000_0000_0000, 64'd0, 1'b1);

    // R2: every destination index
    for (int d = 0; d < 32; d++) begin
      check_hit("R2", mk_word(5'd31 - 5'(d), 5'(d), 5'(d), 6'(d), 1'b1), rnd64(), rnd64(), 1'($urandom()));
    end

    // R1 R9: near-miss words, and valid low
    check_quiet("R9", 1'b0, mk_word(5'd1, 5'd2, 5'd3, 6'd0, 1'b1));
    for (int k = 0; k < 6; k++) begin
      check_quiet("R1", 1'b1, mk_word(5'd1, 5'd2, 5'd3, 6'd0, 1'b1) ^ (32'd1 << (26 + k)));
    end
    for (int k = 0; k < 4; k++) begin
      check_quiet("R1", 1'b1, mk_word(5'd1, 5'd2, 5'd3, 6'd0, 1'b1) ^ (32'd1 << (1 + k)));
    end
    // R1: hit after quiet cycles, then valid drops
    check_hit("R1", mk_word(5'd3, 5'd12, 5'd5, 6'd8, 1'b1), rnd64(), rnd64(), 1'b0);
    check_quiet("R9", 1'b0, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule